// File: doc/BRIEF.md
# Burst Register Write Distributor

This block turns a stream of words, each written to one fixed burst data address, into a sequence of register writes. It sweeps through a set of per-group enable masks. Each enabled register slot takes the next word in the stream. The block issues one write strobe for that word, with the group, the register and the data.

There are seven groups. The master group has index 0, and timer groups A to F have indices 1 to 6. Each group has a 32-bit mask, with one bit per register. The block captures the masks when the first word of a burst arrives, and it holds them until the burst ends. When the last enabled slot has received its word, a one-cycle completion pulse fires together with that final strobe. The next accepted word then starts a new burst at the master group.

Top module: `burst_write_distributor`

## Requirements
- R1: After a synchronous active-low reset, `wr_strobe`, `burst_done`, `wr_group`, `wr_reg` and `wr_word` are all zero. The next accepted word goes to the first enabled slot of the master group (index 0).
- R2: Each accepted word (`in_valid` high, with at least one enabled slot left) produces exactly one `wr_strobe` pulse in the following cycle, and `wr_word` equals the word. A cycle without `in_valid` produces no strobe.
- R3: Slots are served in group order 0 (master), then 1 to 6 (A to F). Within a group they are served in ascending register index, 0 to 31. Group g's mask occupies bits [32*g+31 : 32*g] of `enable_masks`.
- R4: A slot whose mask bit is 0 is skipped and consumes no word.
- R5: `burst_done` is a one-cycle pulse. It is high in the same cycle as the strobe for the last enabled slot, and at no other time.
- R6: When no burst is in progress and all mask bits are 0, an incoming word is ignored: no strobe and no completion pulse.
- R7: The masks are captured on the first word of a burst. Changes to `enable_masks` before the burst ends do not alter the remaining slot sequence.
- R8: The word after a completed burst starts a new burst from the master group, using the masks present at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A word is written to the burst data address |
| in_word | input | 32 | Written word |
| enable_masks | input | 224 | Seven 32-bit group masks, master in the low bits |
| wr_strobe | output | 1 | One-cycle register write strobe |
| wr_group | output | 3 | Target group index (0 master, 1..6 A..F) |
| wr_reg | output | 5 | Target register index within the group |
| wr_word | output | 32 | Data for the target register |
| burst_done | output | 1 | One-cycle burst completion pulse |

## Verification
Every result is due exactly one clock edge after the word that causes it: the strobe, target, data and completion pulse all come from one register stage. The bench drives a single-cycle `in_valid` on a falling edge, and it samples the outputs on the next falling edge. That places each check half a period after the edge that must update them. For ignored words and idle cycles, the bench samples in the same slot and expects the strobe and the completion pulse to be low.

// File: rtl/bwd_pkg.sv
// Package: shared sizing constants for the burst write distributor.
// Assumes one master group plus six timer groups, with 32 registers per group.
package bwd_pkg;
    localparam int GROUPS = 7;
    localparam int REGS   = 32;
    localparam int WORD_W = 32;
endpackage

// File: rtl/bwd_group_scan.sv
// Module: finds the lowest set bit of one group mask.
// Assumes idx is meaningful only while any is high.
module bwd_group_scan #(
    parameter int MASK_W = 32,
    localparam int IDX_W = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0] bits,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    // Priority search: the loop runs downward, so the lowest set bit is assigned last and wins.
    always_comb begin
        idx = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (bits[i]) idx = IDX_W'(i);
        end
        any = |bits;
    end
endmodule

// File: rtl/bwd_group_pick.sv
// Module: selects the lowest-numbered group that still has an enabled slot,
// and forwards that group's register index.
// Assumes the register indices are packed with group 0 in the low bits.
module bwd_group_pick #(
    parameter int NUM_GROUPS = 7,
    parameter int IDX_W      = 5,
    localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
    input  logic [NUM_GROUPS-1:0]       grp_any,
    input  logic [NUM_GROUPS*IDX_W-1:0] grp_idx,
    output logic                        found,
    output logic [GRP_W-1:0]            sel_grp,
    output logic [IDX_W-1:0]            sel_reg
);
    // Group priority: the loop runs downward, so the lowest group with a set bit is assigned last and wins.
    always_comb begin
        sel_grp = '0;
        sel_reg = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (grp_any[g]) begin
                sel_grp = GRP_W'(g);
                sel_reg = grp_idx[g*IDX_W +: IDX_W];
            end
        end
        found = |grp_any;
    end
endmodule

// File: rtl/burst_write_distributor.sv
// Module: routes words written to one burst address onto enabled register slots.
// The slots are taken in group order, then register order.
// Captures the masks on the first word of a burst and clears one bit per word.
// Assumes single-cycle in_valid pulses; every output is registered once.
module burst_write_distributor
    import bwd_pkg::*;
#(
    parameter int NUM_GROUPS = GROUPS,
    parameter int MASK_W     = REGS,
    parameter int DATA_W     = WORD_W,
    localparam int GRP_W     = $clog2(NUM_GROUPS),
    localparam int REG_W     = $clog2(MASK_W),
    localparam int ALL_W     = NUM_GROUPS * MASK_W,
    localparam int FLAT_W    = $clog2(ALL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_word,
    input  logic [ALL_W-1:0]  enable_masks,
    output logic              wr_strobe,
    output logic [GRP_W-1:0]  wr_group,
    output logic [REG_W-1:0]  wr_reg,
    output logic [DATA_W-1:0] wr_word,
    output logic              burst_done
);
    logic                        active;
    logic [ALL_W-1:0]            held;
    logic [ALL_W-1:0]            eff;
    logic [ALL_W-1:0]            remaining;
    logic [NUM_GROUPS-1:0]       grp_any;
    logic [NUM_GROUPS*REG_W-1:0] grp_idx;
    logic                        found;
    logic [GRP_W-1:0]            pick_grp;
    logic [REG_W-1:0]            pick_reg;
    logic [FLAT_W-1:0]           flat_idx;
    logic                        fire;

    // Mask source: the live masks start a burst, and the held masks continue it.
    always_comb eff = active ? held : enable_masks;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_scan
        bwd_group_scan #(.MASK_W(MASK_W)) u_scan (
            .bits (eff[g*MASK_W +: MASK_W]),
            .any  (grp_any[g]),
            .idx  (grp_idx[g*REG_W +: REG_W])
        );
    end

    bwd_group_pick #(.NUM_GROUPS(NUM_GROUPS), .IDX_W(REG_W)) u_pick (
        .grp_any (grp_any),
        .grp_idx (grp_idx),
        .found   (found),
        .sel_grp (pick_grp),
        .sel_reg (pick_reg)
    );

    // Slot consumption: form the flat bit position of the chosen slot and clear it.
    always_comb begin
        flat_idx  = FLAT_W'(pick_grp) * FLAT_W'(MASK_W) + FLAT_W'(pick_reg);
        remaining = eff & ~(ALL_W'(1) << flat_idx);
        fire      = in_valid && found;
    end

    // Walker state and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            held       <= '0;
            wr_strobe  <= 1'b0;
            burst_done <= 1'b0;
            wr_group   <= '0;
            wr_reg     <= '0;
            wr_word    <= '0;
        end else begin
            wr_strobe  <= fire;
            burst_done <= fire && (remaining == '0);
            if (fire) begin
                wr_group <= pick_grp;
                wr_reg   <= pick_reg;
                wr_word  <= in_word;
                held     <= remaining;
                active   <= (remaining != '0);
            end
        end
    end

    // R5: the completion pulse only ever accompanies a strobe.
    a_r5_done_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> wr_strobe);

    // R2: a strobe always follows an incoming word.
    a_r2_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(in_valid));

    // R6: with no burst in progress and all masks zero, a word is dropped.
    a_r6_zero_mask_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && in_valid && enable_masks == '0) |=> (!wr_strobe && !burst_done));

    // R4: the chosen slot is always an enabled one.
    a_r4_chosen_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> eff[flat_idx]);

    // R7: mid-burst words always find a held slot.
    a_r7_held_serves: assert property (@(posedge clk) disable iff (!rst_n)
        (active && in_valid) |=> wr_strobe);
endmodule

// File: tb/burst_write_distributor_bench.sv
module burst_write_distributor_bench;
    localparam int ALL_W = 224;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [31:0]      in_word = '0;
    logic [ALL_W-1:0] enable_masks = '0;
    logic             wr_strobe;
    logic [2:0]       wr_group;
    logic [4:0]       wr_reg;
    logic [31:0]      wr_word;
    logic             burst_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_write_distributor u_burst_write_distributor (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .enable_masks (enable_masks),
        .wr_strobe    (wr_strobe),
        .wr_group     (wr_group),
        .wr_reg       (wr_reg),
        .wr_word      (wr_word),
        .burst_done   (burst_done)
    );

    // Expected slot sequence for the table mask: {done, group[2:0], reg[4:0]}.
    localparam logic [8:0] EXP_SEQ [6] = '{
        {1'b0, 3'd0, 5'd0},
        {1'b0, 3'd0, 5'd3},
        {1'b0, 3'd1, 5'd31},
        {1'b0, 3'd3, 5'd1},
        {1'b0, 3'd3, 5'd2},
        {1'b1, 3'd6, 5'd0}
    };

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Drive one word for one cycle, then sample on the following falling edge.
    task automatic push(input logic [31:0] w);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_mask(input int g, input logic [31:0] m);
        enable_masks[g*32 +: 32] = m;
    endtask

    task automatic expect_slot(input string req, input logic [31:0] w,
                               input logic [2:0] g, input logic [4:0] r, input logic d);
        check(req, {63'd0, wr_strobe}, 64'd1);
        check(req, {61'd0, wr_group}, {61'd0, g});
        check(req, {59'd0, wr_reg}, {59'd0, r});
        check(req, {32'd0, wr_word}, {32'd0, w});
        check(req, {63'd0, burst_done}, {63'd0, d});
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {wr_strobe, burst_done, wr_group, wr_reg, wr_word}, 64'd0);

        // R3 / R4 / R5 / R2: table-driven burst
        set_mask(0, 32'h0000_0009);
        set_mask(1, 32'h8000_0000);
        set_mask(3, 32'h0000_0006);
        set_mask(6, 32'h0000_0001);
        for (int i = 0; i < 6; i++) begin
            push(32'hA000_0000 + 32'(i));
            expect_slot("R3", 32'hA000_0000 + 32'(i), EXP_SEQ[i][7:5], EXP_SEQ[i][4:0], EXP_SEQ[i][8]);
            @(negedge clk);
            // R2: an idle cycle gives no strobe
            check("R2", {62'd0, wr_strobe, burst_done}, 64'd0);
        end

        // R8: the next burst restarts at the master group
        push(32'h1234_5678);
        expect_slot("R8", 32'h1234_5678, 3'd0, 5'd0, 1'b0);

        // R1: reset mid-burst returns the walker to the master group
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", {62'd0, wr_strobe, burst_done}, 64'd0);
        push(32'h0000_0055);
        expect_slot("R1", 32'h0000_0055, 3'd0, 5'd0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R6: all masks zero means the word is ignored
        enable_masks = '0;
        push(32'hDEAD_BEEF);
        check("R6", {62'd0, wr_strobe, burst_done}, 64'd0);

        // R5: a single enabled slot completes at once
        set_mask(4, 32'h0001_0000);
        push(32'h0000_0777);
        expect_slot("R5", 32'h0000_0777, 3'd4, 5'd16, 1'b1);
        @(negedge clk);
        check("R5", {63'd0, burst_done}, 64'd0);

        // R7: a mask change mid-burst has no effect
        enable_masks = '0;
        set_mask(0, 32'h0000_0003);
        push(32'h0000_0001);
        expect_slot("R7", 32'h0000_0001, 3'd0, 5'd0, 1'b0);
        enable_masks = '0;
        set_mask(6, 32'h0000_0020);
        push(32'h0000_0002);
        expect_slot("R7", 32'h0000_0002, 3'd0, 5'd1, 1'b1);

        // R8: the new burst uses the masks present now
        push(32'h0000_0003);
        expect_slot("R8", 32'h0000_0003, 3'd6, 5'd5, 1'b1);

        // R4: a full group skips nothing, and the burst ends at register 31
        enable_masks = '0;
        set_mask(2, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            push(32'(i));
            expect_slot("R4", 32'(i), 3'd2, 5'(i), i == 31);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule